// File: doc/BRIEF.md
# Transmit Descriptor Write-Back Controller

This controller sits beside a transmit DMA engine. One frame may be spread over a chain of descriptors. The engine finishes sending the buffer of one descriptor and then presents a done event. The event carries the descriptor's two-bit frame-position code, its ring index, a frame-error flag and a multi-bit frame-status field. The controller decides whether that descriptor gets a status write-back. Only the first and last descriptors of a frame are written back. Descriptors in the middle of a frame are skipped. The error and status fields reach only the last descriptor, ORed over every descriptor of the frame.

Write-back requests leave on a valid/ready channel. A register holds each request stable while the receiver stalls it. Done events enter through a one-entry skid buffer, so one event can be taken while the request register is occupied. The controller also keeps a bitmap with one active flag per descriptor, which software polls. Software sets a flag when it hands a descriptor to the engine, and an accepted write-back clears it. Software may reuse the descriptors of a frame once the flag of the frame's last descriptor reads 0.

The frame tracker has two states:
- `ST_IDLE`: no frame is open.
- `ST_BODY`: a frame has started and its status is being gathered.

Its transitions are:
- `IDLE->BODY` on a start code.
- `IDLE->IDLE` on a single-descriptor code, or on a sequence error.
- `BODY->BODY` on a middle code.
- `BODY->BODY` on a new start code, which abandons the open frame.
- `BODY->IDLE` on an end code or a single-descriptor code.

Top module: `tx_wb_ctrl`

## Requirements
- R1: A done event with position code 2'b11 (whole frame in one descriptor) yields exactly one write-back. That write-back has `wb_has_stat`=1 and carries the event's own error and status.
- R2: A done event with code 2'b10 (frame start) yields one write-back with `wb_has_stat`=0 and error and status both 0. It opens a frame whose accumulated error and status start from the event's values.
- R3: A done event with code 2'b00 (frame middle) inside an open frame yields no write-back. Its error and status are ORed into the accumulated values, and its active flag stays set.
- R4: A done event with code 2'b01 (frame end) inside an open frame yields one write-back with `wb_has_stat`=1. Its error and status are the OR over every descriptor of the frame, including this one. The frame then closes.
- R5: A code 2'b00 or 2'b01 arriving with no open frame raises `seq_err` for one cycle per event. It yields no write-back and leaves the tracker idle.
- R6: A code 2'b10 or 2'b11 arriving while a frame is open discards the open frame's accumulated status without raising `seq_err`. Processing restarts from the new event.
- R7: While `wb_valid` is high and `wb_ready` is low, `wb_valid` and every write-back field hold their values. Write-backs leave in the order of their done events.
- R8: With the request register stalled, one further done event is accepted into the skid buffer, and `done_ready` then drops. The held event is processed once the stall clears.
- R9: `arm_we` sets the flag `active_map[arm_idx]` on the next clock edge. An accepted write-back (`wb_valid` and `wb_ready` both high) clears `active_map[wb_idx]` on that edge. If both target the same bit on the same edge, the set wins.
- R10: After reset, `active_map` is all zeros, `wb_valid` and `seq_err` are 0, and `done_ready` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| done_valid | input | 1 | Done event present |
| done_ready | output | 1 | Controller can take a done event |
| done_pos | input | 2 | Frame-position code of the finished descriptor |
| done_idx | input | IDX_W | Ring index of the finished descriptor |
| done_err | input | 1 | Frame-error flag reported for this descriptor |
| done_stat | input | STAT_W | Frame-status bits reported for this descriptor |
| wb_valid | output | 1 | Write-back request present |
| wb_ready | input | 1 | Write-back request accepted |
| wb_idx | output | IDX_W | Descriptor to write back (its active flag is cleared) |
| wb_has_stat | output | 1 | Error and status fields are meaningful |
| wb_err | output | 1 | Frame-error value to write |
| wb_stat | output | STAT_W | Frame-status value to write |
| arm_we | input | 1 | Software hands a descriptor to the engine |
| arm_idx | input | IDX_W | Index of the descriptor being armed |
| active_map | output | NUM_DESC | Per-descriptor active flags |
| seq_err | output | 1 | One-cycle pulse on a middle or end code with no open frame |

## Verification
The bench builds the block with NUM_DESC=8 and STAT_W=4. With a ring of eight, the random run wraps the descriptor index many times. Arming and write-back clears then land on reused bits, and now and then both hit the same bit on the same edge. Four status bits leave room for separate bits from separate descriptors, so a missed OR or a missed reset of the accumulated status shows as a wrong value at the end descriptor. Random stalls on `wb_ready` put events into the skid buffer during frames of every length.

// File: rtl/txwb_pkg.sv
package txwb_pkg;
    typedef enum logic [1:0] {
        POS_MID   = 2'b00,
        POS_END   = 2'b01,
        POS_START = 2'b10,
        POS_ONLY  = 2'b11
    } pos_e;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_BODY = 1'b1
    } trk_st_e;
endpackage

// File: rtl/txwb_skid.sv
module txwb_skid #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         in_valid,
    output logic         in_ready,
    input  logic [W-1:0] in_data,
    output logic         out_valid,
    output logic [W-1:0] out_data,
    input  logic         out_take
);
    logic         hold_v;
    logic [W-1:0] hold_d;

    assign in_ready  = !hold_v;
    assign out_valid = hold_v || in_valid;
    assign out_data  = hold_v ? hold_d : in_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold_v <= 1'b0;
            hold_d <= '0;
        end else if (hold_v) begin
            if (out_take) hold_v <= 1'b0;
        end else if (in_valid && !out_take) begin
            hold_v <= 1'b1;
            hold_d <= in_data;
        end
    end

    AST_SKID_CAPTURE: assert property (@(posedge clk) disable iff (!rst_n)
        in_valid && in_ready && !out_take |=> hold_v && hold_d == $past(in_data)); // R8
    AST_SKID_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        hold_v && !out_take |=> hold_v && $stable(hold_d)); // R8
endmodule

// File: rtl/txwb_tracker.sv
module txwb_tracker
    import txwb_pkg::*;
#(
    parameter int IDX_W  = 3,
    parameter int STAT_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ev_valid,
    input  logic [1:0]        ev_pos,
    input  logic [IDX_W-1:0]  ev_idx,
    input  logic              ev_err,
    input  logic [STAT_W-1:0] ev_stat,
    output logic              ev_take,
    output logic              wb_valid,
    input  logic              wb_ready,
    output logic [IDX_W-1:0]  wb_idx,
    output logic              wb_has_stat,
    output logic              wb_err,
    output logic [STAT_W-1:0] wb_stat,
    output logic              seq_err
);
    trk_st_e           st_q, st_d;
    logic              acc_err_q, acc_err_d;
    logic [STAT_W-1:0] acc_stat_q, acc_stat_d;
    logic              emit, emit_hs, emit_err, bad;
    logic [STAT_W-1:0] emit_stat;

    assign ev_take = ev_valid && (!wb_valid || wb_ready);

    always_comb begin
        st_d       = st_q;
        acc_err_d  = acc_err_q;
        acc_stat_d = acc_stat_q;
        emit       = 1'b0;
        emit_hs    = 1'b0;
        emit_err   = 1'b0;
        emit_stat  = '0;
        bad        = 1'b0;
        if (ev_take) begin
            unique case (pos_e'(ev_pos))
                POS_ONLY: begin
                    emit       = 1'b1;
                    emit_hs    = 1'b1;
                    emit_err   = ev_err;
                    emit_stat  = ev_stat;
                    st_d       = ST_IDLE;
                    acc_err_d  = 1'b0;
                    acc_stat_d = '0;
                end
                POS_START: begin
                    emit       = 1'b1;
                    st_d       = ST_BODY;
                    acc_err_d  = ev_err;
                    acc_stat_d = ev_stat;
                end
                POS_MID: begin
                    unique case (st_q)
                        ST_BODY: begin
                            acc_err_d  = acc_err_q | ev_err;
                            acc_stat_d = acc_stat_q | ev_stat;
                        end
                        ST_IDLE: bad = 1'b1;
                    endcase
                end
                POS_END: begin
                    unique case (st_q)
                        ST_BODY: begin
                            emit       = 1'b1;
                            emit_hs    = 1'b1;
                            emit_err   = acc_err_q | ev_err;
                            emit_stat  = acc_stat_q | ev_stat;
                            st_d       = ST_IDLE;
                            acc_err_d  = 1'b0;
                            acc_stat_d = '0;
                        end
                        ST_IDLE: bad = 1'b1;
                    endcase
                end
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q       <= ST_IDLE;
            acc_err_q  <= 1'b0;
            acc_stat_q <= '0;
        end else begin
            st_q       <= st_d;
            acc_err_q  <= acc_err_d;
            acc_stat_q <= acc_stat_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wb_valid    <= 1'b0;
            wb_idx      <= '0;
            wb_has_stat <= 1'b0;
            wb_err      <= 1'b0;
            wb_stat     <= '0;
            seq_err     <= 1'b0;
        end else begin
            seq_err <= bad;
            if (wb_valid && wb_ready) wb_valid <= 1'b0;
            if (emit) begin
                wb_valid    <= 1'b1;
                wb_idx      <= ev_idx;
                wb_has_stat <= emit_hs;
                wb_err      <= emit_err;
                wb_stat     <= emit_stat;
            end
        end
    end

    AST_WB_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_ready |=> wb_valid && $stable(wb_idx) && $stable(wb_has_stat)
            && $stable(wb_err) && $stable(wb_stat)); // R7
    AST_START_NOSTAT: assert property (@(posedge clk) disable iff (!rst_n)
        wb_valid && !wb_has_stat |-> !wb_err && wb_stat == '0); // R2
    AST_SEQERR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        seq_err |-> st_q == ST_IDLE); // R5
    AST_MID_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        ev_take && ev_pos == 2'b00 && !(wb_valid && !wb_ready) |=> !wb_valid); // R3
endmodule

// File: rtl/txwb_actmap.sv
module txwb_actmap #(
    parameter int NUM_DESC = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                set_we,
    input  logic [IDX_W-1:0]    set_idx,
    input  logic                clr_we,
    input  logic [IDX_W-1:0]    clr_idx,
    output logic [NUM_DESC-1:0] map
);
    for (genvar i = 0; i < NUM_DESC; i++) begin : g_flag
        logic flag_q;
        always_ff @(posedge clk) begin
            if (!rst_n)                                   flag_q <= 1'b0;
            else if (set_we && set_idx == IDX_W'(i))      flag_q <= 1'b1;
            else if (clr_we && clr_idx == IDX_W'(i))      flag_q <= 1'b0;
        end
        assign map[i] = flag_q;
    end

    AST_ARM_SETS: assert property (@(posedge clk) disable iff (!rst_n)
        set_we |=> map[$past(set_idx)]); // R9
    AST_WB_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clr_we && !(set_we && set_idx == clr_idx) |=> !map[$past(clr_idx)]); // R9
endmodule

// File: rtl/tx_wb_ctrl.sv
module tx_wb_ctrl #(
    parameter int NUM_DESC = 8,
    parameter int STAT_W   = 4,
    localparam int IDX_W   = $clog2(NUM_DESC)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                done_valid,
    output logic                done_ready,
    input  logic [1:0]          done_pos,
    input  logic [IDX_W-1:0]    done_idx,
    input  logic                done_err,
    input  logic [STAT_W-1:0]   done_stat,
    output logic                wb_valid,
    input  logic                wb_ready,
    output logic [IDX_W-1:0]    wb_idx,
    output logic                wb_has_stat,
    output logic                wb_err,
    output logic [STAT_W-1:0]   wb_stat,
    input  logic                arm_we,
    input  logic [IDX_W-1:0]    arm_idx,
    output logic [NUM_DESC-1:0] active_map,
    output logic                seq_err
);
    localparam int EV_W = 2 + IDX_W + 1 + STAT_W;

    logic            ev_valid, ev_take;
    logic [EV_W-1:0] ev_bus;

    txwb_skid #(.W(EV_W)) u_skid (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_valid (done_valid),
        .in_ready (done_ready),
        .in_data  ({done_pos, done_idx, done_err, done_stat}),
        .out_valid(ev_valid),
        .out_data (ev_bus),
        .out_take (ev_take)
    );

    txwb_tracker #(.IDX_W(IDX_W), .STAT_W(STAT_W)) u_trk (
        .clk        (clk),
        .rst_n      (rst_n),
        .ev_valid   (ev_valid),
        .ev_pos     (ev_bus[EV_W-1 -: 2]),
        .ev_idx     (ev_bus[STAT_W+1 +: IDX_W]),
        .ev_err     (ev_bus[STAT_W]),
        .ev_stat    (ev_bus[STAT_W-1:0]),
        .ev_take    (ev_take),
        .wb_valid   (wb_valid),
        .wb_ready   (wb_ready),
        .wb_idx     (wb_idx),
        .wb_has_stat(wb_has_stat),
        .wb_err     (wb_err),
        .wb_stat    (wb_stat),
        .seq_err    (seq_err)
    );

    txwb_actmap #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_map (
        .clk    (clk),
        .rst_n  (rst_n),
        .set_we (arm_we),
        .set_idx(arm_idx),
        .clr_we (wb_valid && wb_ready),
        .clr_idx(wb_idx),
        .map    (active_map)
    );
endmodule

// File: tb/tx_wb_ctrl_tb.sv
module tx_wb_ctrl_tb;
    localparam int N  = 8;
    localparam int IW = 3;
    localparam int SW = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          done_valid = 1'b0, done_ready;
    logic [1:0]    done_pos = '0;
    logic [IW-1:0] done_idx = '0;
    logic          done_err = 1'b0;
    logic [SW-1:0] done_stat = '0;
    logic          wb_valid, wb_ready = 1'b0, wb_has_stat, wb_err, seq_err;
    logic [IW-1:0] wb_idx;
    logic [SW-1:0] wb_stat;
    logic          arm_we = 1'b0;
    logic [IW-1:0] arm_idx = '0;
    logic [N-1:0]  active_map;

    tx_wb_ctrl #(.NUM_DESC(N), .STAT_W(SW)) u_dut (
        .clk(clk), .rst_n(rst_n),
        .done_valid(done_valid), .done_ready(done_ready), .done_pos(done_pos),
        .done_idx(done_idx), .done_err(done_err), .done_stat(done_stat),
        .wb_valid(wb_valid), .wb_ready(wb_ready), .wb_idx(wb_idx),
        .wb_has_stat(wb_has_stat), .wb_err(wb_err), .wb_stat(wb_stat),
        .arm_we(arm_we), .arm_idx(arm_idx), .active_map(active_map), .seq_err(seq_err)
    );

    typedef struct packed {
        logic [IW-1:0] idx;
        logic          hs;
        logic          err;
        logic [SW-1:0] stat;
    } wb_t;

    wb_t           expq[$];
    int            total = 0, bad = 0, exp_seq = 0, got_seq = 0;
    logic          m_open = 1'b0, m_err = 1'b0;
    logic [SW-1:0] m_stat = '0;
    logic [N-1:0]  exp_map = '0;
    bit            mon_en = 0, rnd_ready = 0, stall_prev = 0;
    wb_t           prev_wb;

    task automatic chk(bit ok, string req, string what, logic [31:0] act, logic [31:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    // Reference model of R1..R6, applied in acceptance order
    function automatic void model(logic [1:0] pos, logic [IW-1:0] idx, logic err, logic [SW-1:0] st);
        case (pos)
            2'b11: begin expq.push_back({idx, 1'b1, err, st}); m_open = 1'b0; end
            2'b10: begin expq.push_back({idx, 1'b0, 1'b0, {SW{1'b0}}});
                         m_open = 1'b1; m_err = err; m_stat = st; end
            2'b00: if (m_open) begin m_err = m_err | err; m_stat = m_stat | st; end
                   else exp_seq++;
            default: if (m_open) begin
                         expq.push_back({idx, 1'b1, m_err | err, m_stat | st}); m_open = 1'b0;
                     end else exp_seq++;
        endcase
    endfunction

    task automatic send(logic [1:0] pos, logic [IW-1:0] idx, logic err, logic [SW-1:0] st);
        bit acc;
        @(posedge clk); #2;
        arm_we = 1'b1; arm_idx = idx;
        @(posedge clk); #2;
        arm_we = 1'b0;
        done_valid = 1'b1; done_pos = pos; done_idx = idx; done_err = err; done_stat = st;
        do begin
            @(negedge clk); acc = done_ready;
            @(posedge clk);
        end while (!acc);
        model(pos, idx, err, st);
        #2 done_valid = 1'b0;
    endtask

    task automatic drain();
        rnd_ready = 0;
        @(posedge clk); #2 wb_ready = 1'b1;
        for (int k = 0; k < 50 && (expq.size() != 0 || wb_valid); k++) @(posedge clk);
        repeat (2) @(posedge clk);
    endtask

    // Monitor: samples mid-cycle, in between driver updates
    always @(negedge clk) begin
        if (rst_n && mon_en) begin
            chk(active_map == exp_map, "R9", "active_map", 32'(active_map), 32'(exp_map));
            if (seq_err) got_seq++;
            if (stall_prev)
                chk(wb_valid && {wb_idx, wb_has_stat, wb_err, wb_stat} == prev_wb, "R7",
                    "stalled request changed", 32'({wb_valid, wb_idx, wb_has_stat, wb_err, wb_stat}),
                    32'({1'b1, prev_wb}));
            if (wb_valid && wb_ready) begin
                if (expq.size() == 0) chk(0, "R5", "unexpected write-back idx", 32'(wb_idx), 0);
                else begin
                    wb_t e;
                    e = expq.pop_front();
                    chk({wb_idx, wb_has_stat, wb_err, wb_stat} == e, e.hs ? "R1/R4" : "R2",
                        "write-back fields", 32'({wb_idx, wb_has_stat, wb_err, wb_stat}), 32'(e));
                end
                exp_map[wb_idx] = 1'b0;
            end
            if (arm_we) exp_map[arm_idx] = 1'b1;
            stall_prev = wb_valid && !wb_ready;
            prev_wb    = {wb_idx, wb_has_stat, wb_err, wb_stat};
        end
    end

    initial begin
        forever begin
            @(posedge clk); #2;
            if (rnd_ready) wb_ready = ($urandom % 4) != 0;
        end
    end

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(20 * 150000);
        total++; bad++;
        $display("FAIL R7 watchdog actual=hung expected=complete");
        finish_run();
    end

    initial begin
        int ring;
        void'($urandom(32'd7741));
        repeat (3) @(posedge clk);
        #2 rst_n = 1'b1;
        @(negedge clk);
        // R10 reset state
        chk(active_map == '0, "R10", "active_map", 32'(active_map), 0);
        chk(!wb_valid, "R10", "wb_valid", 32'(wb_valid), 0);
        chk(done_ready, "R10", "done_ready", 32'(done_ready), 1);
        chk(!seq_err, "R10", "seq_err", 32'(seq_err), 0);
        mon_en = 1;

        // R8: stalled request register plus one held event
        send(2'b11, 3'd1, 1'b1, 4'h5);
        send(2'b11, 3'd2, 1'b0, 4'h3);
        @(negedge clk);
        chk(!done_ready, "R8", "done_ready with held event", 32'(done_ready), 0);
        chk(wb_valid && wb_idx == 3'd1, "R8", "first request idx", 32'(wb_idx), 1);
        drain();
        chk(expq.size() == 0, "R8", "pending write-backs", 32'(expq.size()), 0);
        chk(done_ready, "R8", "done_ready after drain", 32'(done_ready), 1);

        // R2/R3/R4: start, middle, end with ORed status
        send(2'b10, 3'd3, 1'b1, 4'h1);
        send(2'b00, 3'd4, 1'b0, 4'h2);
        send(2'b01, 3'd5, 1'b0, 4'h8);
        drain();
        @(negedge clk);
        chk(active_map[4], "R3", "middle flag kept", 32'(active_map[4]), 1);
        chk(!active_map[3] && !active_map[5], "R4", "start/end flags cleared",
            32'(active_map[5:3]), 32'b010);

        // R5: end code with no open frame
        send(2'b01, 3'd6, 1'b1, 4'hF);
        drain();
        chk(got_seq == 1, "R5", "seq_err pulses", 32'(got_seq), 1);
        chk(active_map[6], "R5", "no write-back for stray end", 32'(active_map[6]), 1);

        // R6: a second start abandons the open frame
        send(2'b10, 3'd7, 1'b1, 4'h4);
        send(2'b10, 3'd0, 1'b0, 4'h1);
        send(2'b01, 3'd1, 1'b0, 4'h2);
        drain();
        chk(got_seq == 1, "R6", "no seq_err on restart", 32'(got_seq), 1);

        // Random frames with random stalls
        rnd_ready = 1;
        ring = 2;
        for (int f = 0; f < 300; f++) begin
            int r, len;
            r = $urandom % 12;
            if (r == 0) begin
                send(($urandom % 2) ? 2'b01 : 2'b00, IW'(ring), 1'($urandom), SW'($urandom));
                ring++;
            end else begin
                len = 1 + $urandom % 4;
                if (len == 1) begin
                    send(2'b11, IW'(ring), 1'($urandom % 5 == 0), SW'($urandom)); ring++;
                end else begin
                    send(2'b10, IW'(ring), 1'($urandom % 5 == 0), SW'($urandom)); ring++;
                    for (int m = 0; m < len - 2; m++) begin
                        send(2'b00, IW'(ring), 1'($urandom % 5 == 0), SW'(1 << ($urandom % SW)));
                        ring++;
                    end
                    if (r != 1) begin
                        send(2'b01, IW'(ring), 1'($urandom % 5 == 0), SW'(1 << ($urandom % SW)));
                        ring++;
                    end
                end
            end
        end
        drain();
        chk(expq.size() == 0, "R7", "write-backs outstanding", 32'(expq.size()), 0);
        chk(got_seq == exp_seq, "R5", "seq_err count", 32'(got_seq), 32'(exp_seq));
        @(negedge clk);
        finish_run();
    end
endmodule